// File: doc/BRIEF.md
# Software Write-Lock Sequence Detector

This block sits on the write path of a byte-wide parallel EEPROM, between the bus-side write latches and the page-load controller. Each accepted write pulse comes with its latched address and data byte. The block watches these writes for keyed command sequences and produces a same-cycle gate that tells the page controller whether this byte may be loaded for programming. A persistent lock flag records whether software protection is on. The flag is modelled as a register that power-on reset does not touch and that starts cleared, which is the factory state.

When the lock is on, no byte reaches the array unless a three-write arm key comes first. After the key, a burst of writes passes until the byte-load timer expires. The arm key also turns the lock on when it is off. A separate six-write key turns the lock off. Any write that breaks a sequence, and any expiry of the byte-load timer, returns the detector to idle.

States: `ST_IDLE` (no sequence in progress), `ST_KEY1` (first key write seen), `ST_KEY2` (second key write seen), `ST_OPEN` (arm key done, burst window open), `ST_DIS3`, `ST_DIS4`, `ST_DIS5` (third, fourth and fifth writes of the disable key seen). The transitions, taken on an accepted write, are:
- `ST_IDLE` to `ST_KEY1` on AAh at the lead address.
- `ST_KEY1` to `ST_KEY2` on 55h at the follow address.
- `ST_KEY2` to `ST_OPEN` on A0h at the lead address, which also sets the lock.
- `ST_KEY2` to `ST_DIS3` on 80h at the lead address.
- `ST_DIS3` to `ST_DIS4` on AAh at the lead address.
- `ST_DIS4` to `ST_DIS5` on 55h at the follow address.
- `ST_DIS5` to `ST_IDLE` on 20h at the lead address, which also clears the lock.
- `ST_OPEN` stays in `ST_OPEN` on any write.

Any other write returns the detector to `ST_IDLE`. A timer expiry returns any state to `ST_IDLE`.

Top module: `spwp_guard`

## Requirements
- R1: While `rst_n` is low and after it is released, the detector is idle, `wr_gate` is low whenever `wr_stb` is low, and `prot_en` reads 0 from the factory.
- R2: With `prot_en` at 0, an ordinary write (one that does not complete a key) drives `wr_gate` high in the same cycle as its `wr_stb`.
- R3: The writes AAh at address 1555h, then 55h at 0AAAh, then A0h at 1555h set `prot_en` to 1 in the cycle after the third write. That third write is not gated through.
- R4: With `prot_en` at 1 and no open burst window, every write is blocked (`wr_gate` low), and this includes the key writes themselves.
- R5: After the arm key, every following write is gated through until `blc_expire` is seen. After that, writes are blocked again while `prot_en` is 1.
- R6: The writes AAh at 1555h, 55h at 0AAAh, 80h at 1555h, AAh at 1555h, 55h at 0AAAh, 20h at 1555h clear `prot_en` in the cycle after the sixth write. The sixth write is not gated through, and ordinary writes pass afterwards.
- R7: A write whose address or data does not match the next expected key step returns the detector to idle, so the rest of the key has no effect.
- R8: A `blc_expire` pulse returns the detector to idle. When it comes in the same cycle as a write, that write is evaluated from idle.
- R9: `rst_n` does not change `prot_en`. The lock value survives a reset.
- R10: `prot_en` changes only in the cycle after an accepted write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequence state |
| wr_stb | input | 1 | One-cycle pulse per accepted write |
| wr_addr | input | AW (13) | Latched write address |
| wr_data | input | DW (8) | Latched write data |
| blc_expire | input | 1 | Byte-load timer expiry pulse |
| wr_gate | output | 1 | High with `wr_stb` when the byte may be programmed |
| prot_en | output | 1 | Persistent software lock flag |

## Verification
The bench builds the block with its default parameters: a 13-bit address, an 8-bit data byte, key addresses 1555h and 0AAAh, and key data AAh, 55h, A0h, 80h and 20h. These widths let the random stimulus send addresses that differ from a key address in exactly one bit. Near-miss addresses of this kind exercise the R7 abort path on every bit of the comparators. Random runs mix whole arm and disable keys, corrupted keys, timer expiries placed inside keys, and resets that fall while the lock is on. Together these reach every state and its exits.

// File: rtl/spwp_pkg.sv
package spwp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_KEY1 = 3'd1,
        ST_KEY2 = 3'd2,
        ST_OPEN = 3'd3,
        ST_DIS3 = 3'd4,
        ST_DIS4 = 3'd5,
        ST_DIS5 = 3'd6
    } spwp_state_e;

    // index of each keyed address/data pair in the hit vector
    localparam int HIT_LEAD_AA   = 0;
    localparam int HIT_FOLLOW_55 = 1;
    localparam int HIT_LEAD_ARM  = 2;
    localparam int HIT_LEAD_PRE  = 3;
    localparam int HIT_LEAD_OFF  = 4;
    localparam int NUM_HITS      = 5;

endpackage

// File: rtl/spwp_key_match.sv
module spwp_key_match
    import spwp_pkg::*;
#(
    parameter int               AW        = 13,
    parameter int               DW        = 8,
    parameter logic [AW-1:0]    ADR_LEAD  = 13'h1555,
    parameter logic [AW-1:0]    ADR_FOLW  = 13'h0AAA,
    parameter logic [DW-1:0]    DAT_LEAD  = 8'hAA,
    parameter logic [DW-1:0]    DAT_FOLW  = 8'h55,
    parameter logic [DW-1:0]    DAT_ARM   = 8'hA0,
    parameter logic [DW-1:0]    DAT_PRE   = 8'h80,
    parameter logic [DW-1:0]    DAT_OFF   = 8'h20
) (
    input  logic [AW-1:0]       addr_i,
    input  logic [DW-1:0]       data_i,
    output logic [NUM_HITS-1:0] hit_o
);

    for (genvar g = 0; g < NUM_HITS; g++) begin : g_key
        localparam logic [AW-1:0] KADR = (g == HIT_FOLLOW_55) ? ADR_FOLW : ADR_LEAD;
        localparam logic [DW-1:0] KDAT =
            (g == HIT_LEAD_AA)   ? DAT_LEAD :
            (g == HIT_FOLLOW_55) ? DAT_FOLW :
            (g == HIT_LEAD_ARM)  ? DAT_ARM  :
            (g == HIT_LEAD_PRE)  ? DAT_PRE  : DAT_OFF;

        logic adr_eq;
        logic dat_eq;
        assign adr_eq   = (addr_i == KADR);
        assign dat_eq   = (data_i == KDAT);
        assign hit_o[g] = adr_eq & dat_eq;
    end

    // R7: one write can match at most one keyed pair
    always_comb begin
        hit_onehot_chk: assert ($onehot0(hit_o) || $isunknown(hit_o));
    end

endmodule

// File: rtl/spwp_seq_fsm.sv
module spwp_seq_fsm
    import spwp_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_stb,
    input  logic                blc_expire,
    input  logic [NUM_HITS-1:0] hit_i,
    input  logic                lock_i,
    output logic                pass_o,
    output logic                set_lock_o,
    output logic                clr_lock_o,
    output spwp_state_e         state_o
);

    spwp_state_e st_q;
    spwp_state_e st_d;
    spwp_state_e st_eff;

    // a timer expiry in the same cycle as a write is applied first
    assign st_eff  = blc_expire ? ST_IDLE : st_q;
    assign state_o = st_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next-state process
    always_comb begin
        st_d = st_eff;
        if (wr_stb) begin
            unique case (st_eff)
                ST_IDLE: st_d = hit_i[HIT_LEAD_AA]   ? ST_KEY1 : ST_IDLE;
                ST_KEY1: st_d = hit_i[HIT_FOLLOW_55] ? ST_KEY2 : ST_IDLE;
                ST_KEY2: begin
                    if (hit_i[HIT_LEAD_ARM])      st_d = ST_OPEN;
                    else if (hit_i[HIT_LEAD_PRE]) st_d = ST_DIS3;
                    else                          st_d = ST_IDLE;
                end
                ST_OPEN: st_d = ST_OPEN;
                ST_DIS3: st_d = hit_i[HIT_LEAD_AA]   ? ST_DIS4 : ST_IDLE;
                ST_DIS4: st_d = hit_i[HIT_FOLLOW_55] ? ST_DIS5 : ST_IDLE;
                ST_DIS5: st_d = ST_IDLE;
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // output process
    always_comb begin
        pass_o     = 1'b0;
        set_lock_o = 1'b0;
        clr_lock_o = 1'b0;
        if (wr_stb) begin
            unique case (st_eff)
                ST_OPEN: pass_o = 1'b1;
                ST_KEY2: begin
                    set_lock_o = hit_i[HIT_LEAD_ARM];
                    pass_o     = !lock_i && !hit_i[HIT_LEAD_ARM];
                end
                ST_DIS5: begin
                    clr_lock_o = hit_i[HIT_LEAD_OFF];
                    pass_o     = !lock_i && !hit_i[HIT_LEAD_OFF];
                end
                ST_IDLE, ST_KEY1, ST_DIS3, ST_DIS4: pass_o = !lock_i;
                default: pass_o = 1'b0;
            endcase
        end
    end

    // R7: the second key step can only be entered from the first
    key2_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_KEY2 && $past(st_q) != ST_KEY2) |-> $past(st_q == ST_KEY1 && wr_stb));

    // R8: an expiry without a write always leaves the detector idle
    expire_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blc_expire && !wr_stb) |=> (st_q == ST_IDLE));

endmodule

// File: rtl/spwp_nv_flag.sv
module spwp_nv_flag (
    input  logic clk,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);

    // persistent cell: not reset by the sequence reset, factory value 0
    logic cell_q = 1'b0;

    always_ff @(posedge clk) begin
        if (set_i)      cell_q <= 1'b1;
        else if (clr_i) cell_q <= 1'b0;
    end

    assign q_o = cell_q;

    // R10: the set and clear commands never coincide
    always_comb begin
        set_clr_excl_chk: assert (!(set_i && clr_i));
    end

endmodule

// File: rtl/spwp_guard.sv
module spwp_guard
    import spwp_pkg::*;
#(
    parameter int               AW        = 13,
    parameter int               DW        = 8,
    parameter logic [AW-1:0]    ADR_LEAD  = 13'h1555,
    parameter logic [AW-1:0]    ADR_FOLW  = 13'h0AAA,
    parameter logic [DW-1:0]    DAT_LEAD  = 8'hAA,
    parameter logic [DW-1:0]    DAT_FOLW  = 8'h55,
    parameter logic [DW-1:0]    DAT_ARM   = 8'hA0,
    parameter logic [DW-1:0]    DAT_PRE   = 8'h80,
    parameter logic [DW-1:0]    DAT_OFF   = 8'h20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          blc_expire,
    output logic          wr_gate,
    output logic          prot_en
);

    logic [NUM_HITS-1:0] hit;
    logic                pass;
    logic                set_lock;
    logic                clr_lock;
    spwp_state_e         state;

    spwp_key_match #(
        .AW(AW), .DW(DW),
        .ADR_LEAD(ADR_LEAD), .ADR_FOLW(ADR_FOLW),
        .DAT_LEAD(DAT_LEAD), .DAT_FOLW(DAT_FOLW),
        .DAT_ARM(DAT_ARM), .DAT_PRE(DAT_PRE), .DAT_OFF(DAT_OFF)
    ) u_match (
        .addr_i (wr_addr),
        .data_i (wr_data),
        .hit_o  (hit)
    );

    spwp_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stb     (wr_stb),
        .blc_expire (blc_expire),
        .hit_i      (hit),
        .lock_i     (prot_en),
        .pass_o     (pass),
        .set_lock_o (set_lock),
        .clr_lock_o (clr_lock),
        .state_o    (state)
    );

    spwp_nv_flag u_lock (
        .clk   (clk),
        .set_i (set_lock),
        .clr_i (clr_lock),
        .q_o   (prot_en)
    );

    assign wr_gate = pass;

    // R10: the lock holds its value unless a write was accepted
    prot_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_stb) |-> $stable(prot_en));

    // R3: the lock rises only right after the arm data at the lead address
    arm_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_en) |-> $past(wr_stb && wr_data == DAT_ARM && wr_addr == ADR_LEAD));

    // R6: the lock falls only right after the off data at the lead address
    dis_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_en) |-> $past(wr_stb && wr_data == DAT_OFF && wr_addr == ADR_LEAD));

    // R1: no gate without a write strobe
    gate_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_gate |-> wr_stb);

    // R5: with the lock on, a gated write needs an open burst window
    gate_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_gate && prot_en && !blc_expire) |-> (state == ST_OPEN));

endmodule

// File: tb/spwp_guard_test.sv
`timescale 1ns/1ps
module spwp_guard_test;

    localparam logic [12:0] KA = 13'h1555;
    localparam logic [12:0] KB = 13'h0AAA;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_stb;
    logic [12:0] wr_addr;
    logic [7:0]  wr_data;
    logic        blc_expire;
    logic        wr_gate;
    logic        prot_en;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // model state: 0 idle,1 key1,2 key2,3 open,4 dis3,5 dis4,6 dis5
    int   m_st   = 0;
    logic m_prot = 1'b0;

    always #2 clk = ~clk;

    spwp_guard uut (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .blc_expire(blc_expire),
        .wr_gate(wr_gate), .prot_en(prot_en)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    function automatic bit is_k(input logic [12:0] a, input logic [7:0] d,
                                input logic [12:0] ka, input logic [7:0] kd);
        return (a == ka) && (d == kd);
    endfunction

    // expected gate and model update from the requirements
    task automatic m_step(input logic stb, input logic ex, input logic [12:0] a,
                          input logic [7:0] d, output logic p);
        int s;
        s = ex ? 0 : m_st;
        p = 1'b0;
        if (stb) begin
            case (s)
                0: begin p = !m_prot; s = is_k(a, d, KA, 8'hAA) ? 1 : 0; end
                1: begin p = !m_prot; s = is_k(a, d, KB, 8'h55) ? 2 : 0; end
                2: begin
                    if (is_k(a, d, KA, 8'hA0)) begin p = 1'b0; s = 3; m_prot = 1'b1; end
                    else begin p = !m_prot; s = is_k(a, d, KA, 8'h80) ? 4 : 0; end
                end
                3: p = 1'b1;
                4: begin p = !m_prot; s = is_k(a, d, KA, 8'hAA) ? 5 : 0; end
                5: begin p = !m_prot; s = is_k(a, d, KB, 8'h55) ? 6 : 0; end
                default: begin
                    if (is_k(a, d, KA, 8'h20)) begin p = 1'b0; m_prot = 1'b0; end
                    else p = !m_prot;
                    s = 0;
                end
            endcase
        end
        m_st = s;
    endtask

    task automatic cyc(input logic stb, input logic ex, input logic [12:0] a,
                       input logic [7:0] d, input string tag);
        logic p;
        @(negedge clk);
        wr_stb = stb; blc_expire = ex; wr_addr = a; wr_data = d;
        #1;
        m_step(stb, ex, a, d, p);
        chk({tag, " gate"}, wr_gate, p);
        @(posedge clk);
        #1;
        chk({tag, " lock"}, prot_en, m_prot);
    endtask

    task automatic wr(input logic [12:0] a, input logic [7:0] d, input string tag);
        cyc(1'b1, 1'b0, a, d, tag);
    endtask

    task automatic arm(input string tag);
        wr(KA, 8'hAA, tag); wr(KB, 8'h55, tag); wr(KA, 8'hA0, tag);
    endtask

    task automatic disarm(input string tag);
        wr(KA, 8'hAA, tag); wr(KB, 8'h55, tag); wr(KA, 8'h80, tag);
        wr(KA, 8'hAA, tag); wr(KB, 8'h55, tag); wr(KA, 8'h20, tag);
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst_n = 1'b0; wr_stb = 1'b0; blc_expire = 1'b0;
        @(posedge clk);
        #1;
        chk({tag, " lock kept"}, prot_en, m_prot);
        m_st = 0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_stb = 1'b0; blc_expire = 1'b0; wr_addr = '0; wr_data = '0;
        void'($urandom(32'd1977));
        #1;
        // R1: reset state
        chk("R1 gate", wr_gate, 1'b0);
        chk("R1 lock", prot_en, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        cyc(1'b0, 1'b0, '0, '0, "R1 idle");

        // R2: unprotected ordinary writes pass
        wr(13'h0100, 8'h3C, "R2");
        wr(KA, 8'h20, "R2");

        // R3: arm key sets the lock, third write not programmed
        arm("R3");
        // R5: burst window passes writes, including key-looking data
        wr(13'h0200, 8'h11, "R5");
        wr(KA, 8'hAA, "R5");
        cyc(1'b0, 1'b1, '0, '0, "R5 expire");
        wr(13'h0201, 8'h22, "R5 closed");

        // R4: key writes themselves blocked while locked
        wr(KA, 8'hAA, "R4");
        wr(KB, 8'h55, "R4");
        cyc(1'b0, 1'b1, '0, '0, "R4");

        // R7: wrong data, then wrong address, abort the key
        wr(KA, 8'hAA, "R7"); wr(KB, 8'h55, "R7"); wr(KA, 8'hA1, "R7");
        wr(13'h0300, 8'h33, "R7 blocked");
        wr(KA, 8'hAA, "R7"); wr(KB ^ 13'h0001, 8'h55, "R7"); wr(KA, 8'hA0, "R7");
        wr(13'h0301, 8'h34, "R7 blocked");

        // R8: expiry mid-key, then expiry coincident with the first write
        wr(KA, 8'hAA, "R8"); wr(KB, 8'h55, "R8");
        cyc(1'b0, 1'b1, '0, '0, "R8");
        wr(KA, 8'hA0, "R8");
        wr(13'h0400, 8'h44, "R8 blocked");
        wr(KA, 8'hAA, "R8");
        cyc(1'b1, 1'b1, KA, 8'hAA, "R8 same-cycle");
        wr(KB, 8'h55, "R8"); wr(KA, 8'hA0, "R8");
        wr(13'h0401, 8'h45, "R8 open");

        // R9: reset does not clear the lock and closes the window
        do_reset("R9");
        wr(13'h0500, 8'h55, "R9 blocked");

        // R6: disable key
        disarm("R6");
        wr(13'h0600, 8'h66, "R6 open");
        do_reset("R9 unlocked");

        // random phase, R10 on every lock sample
        for (int i = 0; i < 1500; i++) begin
            int k;
            k = $urandom_range(0, 19);
            if (k == 0)      arm("R10 rnd arm");
            else if (k == 1) disarm("R10 rnd dis");
            else if (k == 2) do_reset("R9 rnd");
            else if (k == 3) cyc(1'b0, 1'b1, '0, '0, "R8 rnd");
            else begin
                logic [12:0] a;
                logic [7:0]  d;
                int sa, sd;
                sa = $urandom_range(0, 3);
                sd = $urandom_range(0, 5);
                a = (sa == 0) ? KA : (sa == 1) ? KB :
                    (sa == 2) ? (KA ^ (13'h1 << $urandom_range(0, 12))) : 13'($urandom);
                d = (sd == 0) ? 8'hAA : (sd == 1) ? 8'h55 : (sd == 2) ? 8'hA0 :
                    (sd == 3) ? 8'h80 : (sd == 4) ? 8'h20 : 8'($urandom);
                cyc($urandom_range(0, 9) < 8, $urandom_range(0, 9) == 0, a, d, "R10 rnd");
            end
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule